// File: doc/BRIEF.md
# Timer Core with Shadowed Period, Pattern and Compare Registers

This block is a free-running up/down timer whose period, pattern and compare-channel values each live in two places: an active register that the counter logic uses and a shadow register that software may fill at any time. Each shadow register has a pending flag. The flag is set when the shadow register is written. When the counter turns over, a pending shadow value moves into its active register and the flag drops. Because of this, a new period or compare value never takes effect part way through a count cycle. Software can also write an active register directly, and the counter then sees the change at once.

An update lock level stops the hardware copies. A software update strobe forces every pending copy whatever the lock says. Software can drop a pending flag on its own, but only with two clear requests on consecutive cycles. A write is refused, and an access-error pulse is raised, when the target register has a pending shadow value and its synchronization-busy input is high. While both of these hold, the matching read-valid output is low. In down-counting frequency mode with the lock off, the period shadow moves into the active period on every cycle.

Slot numbering is used by the write, clear and busy inputs: slot 0 is the period, slot 1 is the pattern, and slot 2+i is compare channel i.

Top module: `dbuf_timer`

## Requirements
- R1: While reset is asserted and directly after it, the counter is 0, the active period equals RST_PER, the pattern and compare values are 0, every pending flag is 0, and acc_err_o is 0.
- R2: When counting up, the counter increments by one per clock. In a cycle where it is greater than or equal to the active period, ovf_o is high and the counter becomes 0 at the next edge. A period written below the current count therefore causes an immediate wrap.
- R3: When counting down, the counter decrements by one per clock. In a cycle where it is 0, ovf_o is high and the counter loads the active period that held in that cycle.
- R4: An accepted write with wr_buf_i=1 to slot wr_sel_i (0 period, 1 pattern, 2+i compare i) stores the data in that slot's shadow register and sets its pending flag (bufv_o bit = slot). The active value does not change.
- R5: With update lock off, a turnover cycle (ovf_o high) copies every pending shadow value into its active register at the same edge as the counter reload, and clears the flag.
- R6: With lupd_i=1, turnovers copy nothing, and pending flags and active values stay as they are.
- R7: A cycle with sw_update_i=1 copies every pending shadow into its active register and clears the flag, whether or not the lock is on.
- R8: A pending flag clears only when clear requests (vclr_en_i with vclr_sel_i = slot) arrive on two consecutive cycles. A single clear request leaves the flag set.
- R9: A write to a slot whose pending flag and sync_busy_i bit are both 1 is refused. acc_err_o is high in that same cycle, neither register of the slot changes, and rd_ok_o for that slot is low while both conditions hold.
- R10: With dir_down_i=1, freq_mode_i=1 and the lock off, a pending period shadow is copied into the active period at the next edge, whether or not the counter turns over.
- R11: An accepted direct write (wr_buf_i=0) updates the active register at the next edge and leaves the pending flag unchanged. If a copy happens in the same cycle, the direct write takes priority for the active value.
- R12: cmp_o[i] is high in exactly the cycles where the counter equals the active value of compare channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_down_i | input | 1 | 1 = count down |
| freq_mode_i | input | 1 | Frequency mode: period shadow flows through when counting down |
| lupd_i | input | 1 | Update lock: blocks hardware copies |
| sw_update_i | input | 1 | Software update strobe |
| sync_busy_i | input | NSLOT | Synchronization-busy level per slot |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | SEL_W | Target slot of the write |
| wr_buf_i | input | 1 | 1 = write shadow, 0 = write active register |
| wr_data_i | input | CNT_W | Write data |
| vclr_en_i | input | 1 | Pending-flag clear request |
| vclr_sel_i | input | SEL_W | Slot of the clear request |
| cnt_o | output | CNT_W | Counter value |
| per_o | output | CNT_W | Active period |
| patt_o | output | CNT_W | Active pattern |
| cc_o | output | NUM_CC*CNT_W | Active compare values, channel i at bits i*CNT_W |
| bufv_o | output | NSLOT | Pending flags per slot |
| rd_ok_o | output | NSLOT | Active value readable (no write conflict) |
| acc_err_o | output | 1 | Refused-write pulse |
| cmp_o | output | NUM_CC | Compare match per channel |
| ovf_o | output | 1 | Turnover (update condition) |

## Verification
The assertions assume that wr_sel_i and vclr_sel_i always name an existing slot. They also assume that sync_busy_i, lupd_i, dir_down_i and freq_mode_i are levels that change only between edges, so that one request never carries two conflicting meanings. The stimulus drives every select only with slot numbers 0 to 3. It changes mode levels only at the start of a cycle, and it raises a busy bit only around the single refused-write sequence. Strobes last exactly one cycle, except the clear pair, which deliberately spans two consecutive cycles.

// File: rtl/dbuf_pkg.sv
`timescale 1ns/1ps
package dbuf_pkg;
  localparam int SLOT_PER  = 0;
  localparam int SLOT_PATT = 1;
  localparam int SLOT_CC0  = 2;
endpackage

// File: rtl/dbuf_counter.sv
`timescale 1ns/1ps
module dbuf_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_down_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] cnt_q;

  // >= so that a period lowered under the count wraps at once
  assign evt_o = dir_down_i ? (cnt_q == '0) : (cnt_q >= per_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (evt_o)     cnt_q <= dir_down_i ? per_i : '0;
    else if (dir_down_i) cnt_q <= cnt_q - 1'b1;
    else                cnt_q <= cnt_q + 1'b1;
  end

  p_up_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_down_i && cnt_q >= per_i) |=> cnt_q == '0);
  p_down_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_down_i && cnt_q == '0) |=> cnt_q == $past(per_i));
endmodule

// File: rtl/dbuf_slot.sv
`timescale 1ns/1ps
module dbuf_slot #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rst_val_i,
  input  logic         wr_hit_i,
  input  logic         wr_buf_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         clr_hit_i,
  input  logic         busy_i,
  input  logic         upd_evt_i,
  input  logic         lupd_i,
  input  logic         sw_upd_i,
  input  logic         flow_i,
  output logic [W-1:0] act_o,
  output logic         valid_o,
  output logic         rd_ok_o,
  output logic         err_o
);
  logic [W-1:0] act_q, buf_q;
  logic         valid_q, clr_pend_q;
  logic         conflict, wr_ok, copy;

  assign conflict = valid_q & busy_i;
  assign wr_ok    = wr_hit_i & ~conflict;
  assign err_o    = wr_hit_i & conflict;
  assign copy     = valid_q & (sw_upd_i | (~lupd_i & (upd_evt_i | flow_i)));
  assign act_o    = act_q;
  assign valid_o  = valid_q;
  assign rd_ok_o  = ~conflict;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= rst_val_i;
      buf_q      <= '0;
      valid_q    <= 1'b0;
      clr_pend_q <= 1'b0;
    end else begin
      if (copy) begin
        act_q   <= buf_q;
        valid_q <= 1'b0;
      end
      if (clr_hit_i && clr_pend_q) valid_q <= 1'b0;
      if (wr_ok) begin
        if (wr_buf_i) begin
          buf_q   <= wr_data_i;
          valid_q <= 1'b1;
        end else begin
          act_q <= wr_data_i;
        end
      end
      clr_pend_q <= clr_hit_i;
    end
  end

  p_buf_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && wr_buf_i) |=> (valid_q && buf_q == $past(wr_data_i)));
  p_hw_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && upd_evt_i && !lupd_i && !wr_ok) |=> (!valid_q && act_q == $past(buf_q)));
  p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && lupd_i && !sw_upd_i && !wr_hit_i && !clr_hit_i) |=> (valid_q && $stable(act_q)));
  p_sw_copy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && sw_upd_i && !wr_ok) |=> act_q == $past(buf_q));
  p_one_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && clr_hit_i && !clr_pend_q && !copy) |=> valid_q);
  p_reject_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(buf_q));
endmodule

// File: rtl/dbuf_timer.sv
`timescale 1ns/1ps
module dbuf_timer #(
  parameter int          CNT_W   = 16,
  parameter int          NUM_CC  = 2,
  parameter int unsigned RST_PER = 15,
  localparam int         NSLOT   = 2 + NUM_CC,
  localparam int         SEL_W   = $clog2(NSLOT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dir_down_i,
  input  logic                    freq_mode_i,
  input  logic                    lupd_i,
  input  logic                    sw_update_i,
  input  logic [NSLOT-1:0]        sync_busy_i,
  input  logic                    wr_en_i,
  input  logic [SEL_W-1:0]        wr_sel_i,
  input  logic                    wr_buf_i,
  input  logic [CNT_W-1:0]        wr_data_i,
  input  logic                    vclr_en_i,
  input  logic [SEL_W-1:0]        vclr_sel_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [CNT_W-1:0]        per_o,
  output logic [CNT_W-1:0]        patt_o,
  output logic [NUM_CC*CNT_W-1:0] cc_o,
  output logic [NSLOT-1:0]        bufv_o,
  output logic [NSLOT-1:0]        rd_ok_o,
  output logic                    acc_err_o,
  output logic [NUM_CC-1:0]       cmp_o,
  output logic                    ovf_o
);
  import dbuf_pkg::*;

  logic [CNT_W-1:0] act [NSLOT];
  logic [NSLOT-1:0] err;
  logic             upd_evt;

  dbuf_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dir_down_i (dir_down_i),
    .per_i      (act[SLOT_PER]),
    .cnt_o      (cnt_o),
    .evt_o      (upd_evt)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [CNT_W-1:0] RV = (k == SLOT_PER) ? CNT_W'(RST_PER) : '0;
    logic flow;
    if (k == SLOT_PER) begin : g_flow
      assign flow = dir_down_i & freq_mode_i;
    end else begin : g_noflow
      assign flow = 1'b0;
    end
    dbuf_slot #(.W(CNT_W)) i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rst_val_i (RV),
      .wr_hit_i  (wr_en_i && (wr_sel_i == SEL_W'(k))),
      .wr_buf_i  (wr_buf_i),
      .wr_data_i (wr_data_i),
      .clr_hit_i (vclr_en_i && (vclr_sel_i == SEL_W'(k))),
      .busy_i    (sync_busy_i[k]),
      .upd_evt_i (upd_evt),
      .lupd_i    (lupd_i),
      .sw_upd_i  (sw_update_i),
      .flow_i    (flow),
      .act_o     (act[k]),
      .valid_o   (bufv_o[k]),
      .rd_ok_o   (rd_ok_o[k]),
      .err_o     (err[k])
    );
  end

  for (genvar i = 0; i < NUM_CC; i++) begin : g_cc
    assign cc_o[i*CNT_W +: CNT_W] = act[SLOT_CC0+i];
    assign cmp_o[i] = (cnt_o == act[SLOT_CC0+i]);
  end

  assign per_o     = act[SLOT_PER];
  assign patt_o    = act[SLOT_PATT];
  assign acc_err_o = |err;
  assign ovf_o     = upd_evt;

  p_flow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_down_i && freq_mode_i && !lupd_i && bufv_o[SLOT_PER] &&
     !(wr_en_i && wr_sel_i == SEL_W'(SLOT_PER))) |=> !bufv_o[SLOT_PER]);
  p_err_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> (wr_en_i && !rd_ok_o[wr_sel_i]));
endmodule

// File: tb/test_dbuf_timer.sv
`timescale 1ns/1ps
module test_dbuf_timer;
  localparam int W = 16, NCC = 2, NS = 4, RP = 15;

  logic clk = 0, rst_n = 0;
  logic dir_down = 0, freq = 0, lupd = 0, swu = 0;
  logic [NS-1:0] busy = '0;
  logic wr_en = 0, wr_buf = 0, vclr = 0;
  logic [1:0] wr_sel = '0, vclr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt_o, per_o, patt_o;
  logic [NCC*W-1:0] cc_o;
  logic [NS-1:0] bufv_o, rd_ok_o;
  logic acc_err_o, ovf_o;
  logic [NCC-1:0] cmp_o;

  int nchk = 0, nerr = 0;
  bit done = 0;
  int m_cnt;
  int m_act[NS], m_buf[NS];
  bit m_v[NS], m_pend[NS];
  int p_save;

  always #10 clk = ~clk;

  dbuf_timer #(.CNT_W(W), .NUM_CC(NCC), .RST_PER(RP)) i_dbuf_timer (
    .clk_i(clk), .rst_ni(rst_n), .dir_down_i(dir_down), .freq_mode_i(freq),
    .lupd_i(lupd), .sw_update_i(swu), .sync_busy_i(busy), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_buf_i(wr_buf), .wr_data_i(wr_data), .vclr_en_i(vclr),
    .vclr_sel_i(vclr_sel), .cnt_o(cnt_o), .per_o(per_o), .patt_o(patt_o), .cc_o(cc_o),
    .bufv_o(bufv_o), .rd_ok_o(rd_ok_o), .acc_err_o(acc_err_o), .cmp_o(cmp_o), .ovf_o(ovf_o));

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare all outputs, then advance the model by one edge
  task automatic at_neg();
    bit upd, exp_err;
    @(negedge clk);
    upd = dir_down ? (m_cnt == 0) : (m_cnt >= m_act[0]);
    exp_err = 0;
    for (int k = 0; k < NS; k++)
      if (wr_en && wr_sel == k && m_v[k] && busy[k]) exp_err = 1;
    chk(dir_down ? "R3 cnt" : "R2 cnt", cnt_o, m_cnt);
    chk("R2 ovf", ovf_o, upd);
    chk("R5 per", per_o, m_act[0]);
    chk("R5 patt", patt_o, m_act[1]);
    chk("R9 err", acc_err_o, exp_err);
    for (int i = 0; i < NCC; i++) begin
      chk("R5 cc", cc_o[i*W +: W], m_act[2+i]);
      chk("R12 cmp", cmp_o[i], m_cnt == m_act[2+i]);
    end
    for (int k = 0; k < NS; k++) begin
      chk("R4 bufv", bufv_o[k], m_v[k]);
      chk("R9 rd_ok", rd_ok_o[k], !(m_v[k] && busy[k]));
    end
    for (int k = 0; k < NS; k++) begin
      bit cp, hit, clr;
      hit = wr_en && wr_sel == k;
      clr = vclr && vclr_sel == k;
      cp = m_v[k] && (swu || (!lupd && (upd || (k == 0 && dir_down && freq))));
      if (cp) begin m_act[k] = m_buf[k]; m_v[k] = 0; end
      if (clr && m_pend[k]) m_v[k] = 0;
      if (hit && !(m_v[k] && busy[k])) begin
        if (wr_buf) begin m_buf[k] = wr_data; m_v[k] = 1; end
        else m_act[k] = wr_data;
      end
      m_pend[k] = clr;
    end
    if (upd) m_cnt = dir_down ? m_act_old0 : 0;
    else m_cnt = dir_down ? m_cnt - 1 : m_cnt + 1;
  endtask

  int m_act_old0;
  always @(negedge clk) m_act_old0 = m_act[0];

  task automatic to_pos();
    @(posedge clk); #1;
    wr_en = 0; vclr = 0; swu = 0;
  endtask

  task automatic step(); at_neg(); to_pos(); endtask
  task automatic run(int n); repeat (n) step(); endtask
  task automatic wr(int sel, bit b, int d);
    wr_en = 1; wr_sel = 2'(sel); wr_buf = b; wr_data = W'(d);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    m_cnt = 0;
    for (int k = 0; k < NS; k++) begin
      m_act[k] = (k == 0) ? RP : 0; m_buf[k] = 0; m_v[k] = 0; m_pend[k] = 0;
    end
    repeat (2) @(negedge clk);
    chk("R1 cnt", cnt_o, 0);
    chk("R1 per", per_o, RP);
    chk("R1 bufv", bufv_o, 0);
    chk("R1 err", acc_err_o, 0);
    chk("R1 cc", cc_o, 0);
    @(posedge clk); #1 rst_n = 1;

    run(40);
    // R2: period lowered under count wraps at once; R11 direct write
    while (cnt_o != 10) step();
    wr(0, 0, 5); step();
    chk("R11 per", per_o, 5);
    chk("R11 bufv", bufv_o[0], 0);
    chk("R2 cnt", cnt_o, 11);
    step();
    chk("R2 wrap", cnt_o, 0);
    // R4/R5 buffered period
    wr(0, 1, 9); step();
    chk("R4 bufv", bufv_o[0], 1);
    chk("R4 per", per_o, 5);
    run(8);
    chk("R5 bufv", bufv_o[0], 0);
    chk("R5 per", per_o, 9);
    // compare channels buffered, R12 via model
    wr(2, 1, 3); step();
    wr(3, 1, 7); step();
    wr(1, 1, 21); step();
    run(25);
    // R6 lock, R7 software update
    lupd = 1; p_save = per_o;
    wr(0, 1, 12); step();
    run(30);
    chk("R6 per", per_o, p_save);
    chk("R6 bufv", bufv_o[0], 1);
    swu = 1; step();
    chk("R7 per", per_o, 12);
    chk("R7 bufv", bufv_o[0], 0);
    // R8 double clear
    wr(2, 1, 4); step();
    vclr = 1; vclr_sel = 2; step();
    step();
    chk("R8 single", bufv_o[2], 1);
    vclr = 1; vclr_sel = 2; step();
    vclr = 1; vclr_sel = 2; step();
    chk("R8 double", bufv_o[2], 0);
    chk("R8 cc0", cc_o[0 +: W], 3);
    // R9 refused write
    wr(3, 1, 9); step();
    busy = 4'b1000;
    wr(3, 1, 2); at_neg();
    chk("R9 err", acc_err_o, 1);
    chk("R9 rd_ok", rd_ok_o[3], 0);
    to_pos();
    wr(3, 0, 1); step();
    chk("R9 bufv", bufv_o[3], 1);
    chk("R9 cc1", cc_o[W +: W], 7);
    busy = '0;
    swu = 1; step();
    chk("R7 cc1", cc_o[W +: W], 9);
    // R11 direct write wins over concurrent copy
    wr(0, 1, 10); step();
    wr(0, 0, 6); swu = 1; step();
    chk("R11 prio", per_o, 6);
    chk("R11 bufv", bufv_o[0], 0);
    lupd = 0;
    // R3 down counting
    dir_down = 1;
    run(20);
    while (cnt_o != 0) step();
    step();
    chk("R3 reload", cnt_o, 6);
    // R10 flow-through period
    freq = 1;
    wr(0, 1, 8); step();
    chk("R10 bufv", bufv_o[0], 1);
    step();
    chk("R10 per", per_o, 8);
    chk("R10 bufv", bufv_o[0], 0);
    run(30);
    freq = 0; dir_down = 0;
    run(20);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule